// File: doc/BRIEF.md
# Byte-Chained Arithmetic Unit

This unit performs 8-bit add, subtract and compare operations for a load/store core, along with carry-chained forms of each. A compiler can therefore build 16-bit and 32-bit arithmetic and comparisons from a run of byte steps. The core supplies three things each cycle:

- an operation code;
- a first operand and a second operand, where the second comes either from a register or from an immediate field;
- the carry and zero flags left by the previous step.

The unit registers its answer on that clock edge. The answer is the byte result, a write-back enable, and a new five-flag word.

In the chained subtract and chained compare, the zero flag can only be kept or cleared. It can never be set. A zero result in an upper byte therefore cannot hide a difference in a lower byte. After the last byte, the zero flag, the carry flag and the signed flags all describe the whole multi-byte value. Compares produce flags only and never request a register write.

The core feeds `flags_out` back into `carry_in` and `zero_in` between the steps of a chain. An opcode outside the six defined codes is refused: no result is presented and the held outputs do not change.

Top module: `chain_alu`

## Requirements
- R1: While reset is active, and after it is released with no operation issued, `result_valid` and `result_we` are 0 and `result` and `flags_out` are all zeros.
- R2: An operation presented with `op_valid`=1 on a rising edge appears on the outputs immediately after that edge, with `result_valid`=1 for that one cycle. With `op_valid`=0, `result_valid` and `result_we` are 0 on the following cycle.
- R3: `op_code` is encoded as 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 compare-with-borrow. `use_imm`=1 takes the second operand from `imm_val`, and `use_imm`=0 takes it from `src_b`.
- R4: Add produces (a+b) mod 256. Add-with-carry produces (a+b+`carry_in`) mod 256. The C flag is the carry out of bit 7.
- R5: Subtract and compare compute (a-b) mod 256. The borrowing forms compute (a-b-`carry_in`) mod 256. C is 1 exactly when the full unsigned subtraction, including the incoming borrow, goes below zero.
- R6: For add, add-with-carry, subtract and compare, Z is 1 exactly when the 8-bit result is zero. `zero_in` is ignored for these operations.
- R7: For subtract-with-borrow and compare-with-borrow, Z is 1 only when the 8-bit result is zero and `zero_in` is 1. Otherwise Z is 0.
- R8: The flag word is laid out as bit0 C, bit1 Z, bit2 N, bit3 V, bit4 S. N equals result bit 7, V is two's-complement overflow of the operation, and S = N xor V.
- R9: Compare and compare-with-borrow update `result` and `flags_out` but leave `result_we` at 0. The other four operations drive `result_we`=1.
- R10: Opcodes 6 and 7 give `result_valid`=0 and `result_we`=0, and leave `result` and `flags_out` unchanged.
- R11: Subtracting 0xE101 from 0xE104 as subtract followed by subtract-with-borrow gives 0x03 with Z=0 and then 0x00 with Z=0. A plain compare followed by three compare-with-borrow steps leaves C, Z, N, V and S equal to those of the full 32-bit subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select (see R3) |
| use_imm | input | 1 | Take second operand from `imm_val` |
| src_a | input | 8 | First operand |
| src_b | input | 8 | Second operand, register form |
| imm_val | input | 8 | Second operand, immediate form |
| carry_in | input | 1 | Carry/borrow flag from the previous step |
| zero_in | input | 1 | Zero flag from the previous step |
| result | output | 8 | Byte result |
| result_we | output | 1 | Result should be written to a register |
| flags_out | output | 5 | Updated flags {S,V,N,Z,C} |
| result_valid | output | 1 | Outputs hold a newly completed operation |

## Verification
A fault in the opcode decode shows one cycle after issue, as a wrong `result_we` or `result_valid`, or as a wrong choice of carry use. A broken adder stage or borrow inversion corrupts `result` and C in that same next cycle for the affected operand patterns. An error in the zero chaining appears only on the borrowing forms. When `zero_in` is 0 it shows as a Z that is set where it must stay clear. For that reason every byte of every chained sequence is checked as it completes, and the final flags are not the only thing checked.

// File: rtl/chain_alu_pkg.sv
package chain_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_CMP = 3'd4,
        OP_CPC = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import chain_alu_pkg::*;
(
    input  logic [2:0] code,
    output logic       legal,
    output logic       is_sub,
    output logic       use_cin,
    output logic       chain_z,
    output logic       writes
);

    always_comb begin
        legal   = 1'b1;
        is_sub  = 1'b0;
        use_cin = 1'b0;
        chain_z = 1'b0;
        writes  = 1'b1;
        unique case (code)
            OP_ADD: ;
            OP_ADC: use_cin = 1'b1;
            OP_SUB: is_sub  = 1'b1;
            OP_SBC: begin
                is_sub  = 1'b1;
                use_cin = 1'b1;
                chain_z = 1'b1;
            end
            OP_CMP: begin
                is_sub = 1'b1;
                writes = 1'b0;
            end
            OP_CPC: begin
                is_sub  = 1'b1;
                use_cin = 1'b1;
                chain_z = 1'b1;
                writes  = 1'b0;
            end
            default: begin
                legal  = 1'b0;
                writes = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_chain_adder.sv
module alu_chain_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W:0]   cy;
    logic [W-1:0] bx;

    assign bx    = sub ? ~b : b;
    assign cy[0] = sub ? ~cin : cin;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ bx[i] ^ cy[i];
            assign cy[i+1] = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
        end
    endgenerate

    assign cout = sub ? ~cy[W] : cy[W];
    assign ovf  = cy[W] ^ cy[W-1];

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import chain_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sum,
    input  logic         cout,
    input  logic         ovf,
    input  logic         chain_z,
    input  logic         z_prev,
    output alu_flags_t   flags
);

    logic byte_zero;
    assign byte_zero = (sum == '0);

    always_comb begin
        flags.c = cout;
        flags.z = byte_zero & (chain_z ? z_prev : 1'b1);
        flags.n = sum[W-1];
        flags.v = ovf;
        flags.s = sum[W-1] ^ ovf;
    end

endmodule

// File: rtl/chain_alu.sv
module chain_alu
    import chain_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] imm_val,
    input  logic              carry_in,
    input  logic              zero_in,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [4:0]        flags_out,
    output logic              result_valid
);

    localparam int FLAG_W = $bits(alu_flags_t);

    logic              legal, is_sub, use_cin, chain_z, writes;
    logic [DATA_W-1:0] opnd_b, sum;
    logic              cout, ovf, cin_eff;
    alu_flags_t        next_flags;
    alu_flags_t        flags_q;
    alu_op_e           op_q;
    logic              zin_q;
    logic              accept;

    alu_op_decode u_dec (
        .code    (op_code),
        .legal   (legal),
        .is_sub  (is_sub),
        .use_cin (use_cin),
        .chain_z (chain_z),
        .writes  (writes)
    );

    assign opnd_b  = use_imm ? imm_val : src_b;
    assign cin_eff = use_cin & carry_in;

    alu_chain_adder #(.W(DATA_W)) u_add (
        .a    (src_a),
        .b    (opnd_b),
        .cin  (cin_eff),
        .sub  (is_sub),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf)
    );

    alu_flag_gen #(.W(DATA_W)) u_flg (
        .sum     (sum),
        .cout    (cout),
        .ovf     (ovf),
        .chain_z (chain_z),
        .z_prev  (zero_in),
        .flags   (next_flags)
    );

    assign accept = op_valid & legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
            result_we    <= 1'b0;
            result       <= '0;
            flags_q      <= '0;
            op_q         <= OP_ADD;
            zin_q        <= 1'b0;
        end else begin
            result_valid <= accept;
            result_we    <= accept & writes;
            if (accept) begin
                result  <= sum;
                flags_q <= next_flags;
                op_q    <= alu_op_e'(op_code);
                zin_q   <= zero_in;
            end
        end
    end

    assign flags_out = FLAG_W'(flags_q);

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && (op_q == OP_CMP || op_q == OP_CPC)) |-> !result_we); // R9

    AST_CHAIN_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && (op_q == OP_SBC || op_q == OP_CPC) && !zin_q) |-> !flags_out[1]); // R7

    AST_NEG_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (flags_out[2] == result[DATA_W-1])); // R8

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> !result_we); // R2

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !legal) |=> (!result_valid && $stable(flags_out) && $stable(result))); // R10

endmodule

// File: tb/chain_alu_tb_top.sv
module chain_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic       use_imm = 1'b0;
    logic [7:0] src_a = 8'h00, src_b = 8'h00, imm_val = 8'h00;
    logic       carry_in = 1'b0, zero_in = 1'b0;
    logic [7:0] result;
    logic       result_we;
    logic [4:0] flags_out;
    logic       result_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    chain_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .use_imm(use_imm), .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
        .carry_in(carry_in), .zero_in(zero_in), .result(result),
        .result_we(result_we), .flags_out(flags_out), .result_valid(result_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected {we, flags[4:0], res[7:0]} computed with integer arithmetic
    function automatic logic [13:0] model(input int op, input int a, input int b,
                                          input int cin, input int zin);
        int sa, sb, u, s, r;
        logic c, z, n, v, we;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        if (op <= 1) begin
            u = a + b + ((op == 1) ? cin : 0);
            s = sa + sb + ((op == 1) ? cin : 0);
            c = (u > 255);
        end else begin
            u = a - b - ((op == 3 || op == 5) ? cin : 0);
            s = sa - sb - ((op == 3 || op == 5) ? cin : 0);
            c = (u < 0);
        end
        r  = u & 255;
        v  = (s > 127) || (s < -128);
        n  = (r > 127);
        z  = (r == 0) && ((op == 3 || op == 5) ? (zin != 0) : 1'b1);
        we = (op < 4);
        return {we, n ^ v, v, n, z, c, r[7:0]};
    endfunction

    // drive inputs after an edge, sample one ns after the next rising edge
    task automatic issue(input int op, input logic [7:0] a, input logic [7:0] b,
                         input logic imm, input logic ci, input logic zi);
        op_valid = 1'b1;
        op_code  = op[2:0];
        use_imm  = imm;
        src_a    = a;
        src_b    = imm ? ~b : b;
        imm_val  = imm ? b : ~b;
        carry_in = ci;
        zero_in  = zi;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [13:0] e;
        logic [7:0]  hold_r;
        logic [4:0]  hold_f;
        logic [31:0] ra, rb, seed;
        #2;
        chk("R1 valid in reset", {31'd0, result_valid}, 0);
        chk("R1 outputs in reset", {18'd0, result_we, flags_out, result}, 0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 idle after reset", {17'd0, result_valid, result_we, flags_out, result}, 0);

        // near-exhaustive sweep: every a, 64 b values per a covering all b overall
        for (int op = 0; op < 6; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 64; k++) begin
                    int b;
                    logic ci, zi, im;
                    b  = k * 4 + (a % 4);
                    ci = a[2] ^ k[0];
                    zi = a[3] ^ k[1];
                    im = k[2] ^ a[0];
                    issue(op, a[7:0], b[7:0], im, ci, zi);
                    e = model(op, a, b, ci, zi);
                    chk("R2 R3 R4 R5 R6 R7 R8 R9 sweep",
                        {16'd0, result_valid, result_we, flags_out, result},
                        {16'd0, 1'b1, e});
                end
            end
        end

        // R2: no op issued -> nothing valid
        @(posedge clk); #1;
        chk("R2 idle cycle", {30'd0, result_valid, result_we}, 0);

        // R10: illegal opcodes keep state
        issue(2, 8'h10, 8'h10, 1'b0, 1'b0, 1'b0);
        hold_r = result; hold_f = flags_out;
        for (int op = 6; op < 8; op++) begin
            issue(op, 8'h7f, 8'h01, 1'b0, 1'b1, 1'b1);
            chk("R10 illegal op", {17'd0, result_valid, result_we, flags_out, result},
                {17'd0, 1'b0, 1'b0, hold_f, hold_r});
        end

        // R11: 16-bit example
        issue(2, 8'h04, 8'h01, 1'b0, 1'b0, 1'b0);
        chk("R11 low byte", {19'd0, flags_out[1], result}, {19'd0, 1'b0, 8'h03});
        issue(3, 8'hE1, 8'hE1, 1'b0, flags_out[0], flags_out[1]);
        chk("R11 high byte", {18'd0, flags_out[1], flags_out[0], result},
            {18'd0, 1'b0, 1'b0, 8'h00});

        // R11: 32-bit compare chains
        seed = 32'h1234_5678;
        for (int t = 0; t < 300; t++) begin
            longint da, db, d;
            logic ec, ez, en, ev;
            seed = seed * 32'd1664525 + 32'd1013904223;
            ra   = seed;
            seed = seed * 32'd1664525 + 32'd1013904223;
            case (t % 4)
                0: rb = seed;
                1: rb = ra;
                2: rb = ra ^ 32'h0000_0001;
                default: rb = {ra[31:8], seed[7:0]};
            endcase
            issue(4, ra[7:0], rb[7:0], 1'b0, 1'b0, 1'b0);
            chk("R9 cmp no write", {31'd0, result_we}, 0);
            for (int i = 1; i < 4; i++) begin
                issue(5, ra[8*i +: 8], rb[8*i +: 8], t[0], flags_out[0], flags_out[1]);
                chk("R9 cpc no write", {31'd0, result_we}, 0);
            end
            da = longint'(ra); db = longint'(rb);
            ec = (da < db);
            ez = (ra == rb);
            da = longint'($signed(ra)); db = longint'($signed(rb));
            d  = da - db;
            en = d[31];
            ev = (d > 64'sd2147483647) || (d < -64'sd2147483648);
            chk("R11 32-bit compare flags", {27'd0, flags_out},
                {27'd0, en ^ ev, ev, en, ez, ec});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule